// File: doc/BRIEF.md
# Valid-Handshake Memory Bus Master

This block sits between a processor core and a memory that answers over a fully interlocked four-phase valid handshake. The core hands it one transaction at a time: an address, a direction, a kind (instruction fetch or data access) and, for a store, the write data. The block drives these onto the bus and raises its valid strobe. It then waits for the memory's valid response and captures read data on the first edge where that response is seen. After that it drops its strobe and waits for the memory to withdraw its response before it takes the next request.

A single-cycle completion pulse tells the core that the access has finished. The returned read data stays on the core side until the next read completes. While a transaction is in flight the block reports busy, and any request from the core during that time is ignored. Every store is tagged as a data access, even when the core marks it as a fetch.

Top module: `vhs_bus_master`

## Requirements
- R1: While reset is held and in the first cycle after it, `bus_cpu_vld`, `bus_dout_en`, `core_busy` and `core_done` are all 0.
- R2: A request sampled with `core_busy` low is accepted. In the next cycle `bus_cpu_vld` is 1, and `bus_addr` and `bus_rw` (1 = read, 0 = write) match the request. For a read, `bus_dkind` is the inverse of `core_fetch` (1 = data access, 0 = instruction fetch).
- R3: In every cycle in which `bus_cpu_vld` stays 1, `bus_addr`, `bus_rw`, `bus_dkind` and `bus_dout` are unchanged from the cycle before.
- R4: `bus_cpu_vld` stays 1 until an edge samples `bus_mem_vld` as 1. It is 0 in the cycle right after the first such edge.
- R5: On a read, `core_rdata` takes the value of `bus_din` sampled on the first edge with `bus_mem_vld` high. It keeps that value through later writes until the next read completes.
- R6: `core_done` is high for exactly one cycle per transaction: the cycle after the edge that samples `bus_mem_vld` high.
- R7: A write drives `bus_dkind` as 1 whatever `core_fetch` says. It drives `bus_dout` with the write data and `bus_dout_en` as 1 while `bus_cpu_vld` is 1.
- R8: After `bus_cpu_vld` falls, `core_busy` stays 1 and no new transaction starts until an edge samples `bus_mem_vld` as 0.
- R9: A request while `core_busy` is 1 has no effect. The bus signals of the running transaction do not change, and no extra transaction or completion pulse occurs.
- R10: During a read `bus_dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| core_req | input | 1 | Core requests a transaction |
| core_addr | input | AW | Transaction address |
| core_read | input | 1 | 1 = read, 0 = write |
| core_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| core_wdata | input | DW | Write data |
| core_busy | output | 1 | A transaction is in flight; requests are ignored |
| core_done | output | 1 | One-cycle completion pulse |
| core_rdata | output | DW | Last captured read data |
| bus_addr | output | AW | Bus address |
| bus_rw | output | 1 | Bus direction, 1 = read |
| bus_dkind | output | 1 | 1 = data access, 0 = instruction fetch |
| bus_dout | output | DW | Write data toward memory |
| bus_dout_en | output | 1 | Write data is being driven |
| bus_din | input | DW | Read data from memory |
| bus_cpu_vld | output | 1 | Master valid strobe |
| bus_mem_vld | input | 1 | Memory valid response |

## Verification
The hardest case to reach from the ports is the release phase. The memory keeps its response high after the strobe has fallen, and the core tries to start something during that window and during a long wait for the response. The bench responder takes a per-transaction response latency and a per-transaction hold time for the release. Some transactions use a latency of zero and others use long latencies and long holds. During one long wait the driver presses a conflicting request for several cycles. The responder then confirms that the bus fields never move and that busy stays high through the release. A final count confirms that no extra completion came from that request.

// File: rtl/vhs_pkg.sv
// Package: shared types for the valid-handshake bus master.
// Assumes nothing beyond a single clock domain.
package vhs_pkg;
    typedef enum logic [1:0] {
        HS_IDLE    = 2'd0,
        HS_REQ     = 2'd1,
        HS_RELEASE = 2'd2
    } hs_state_t;
endpackage

// File: rtl/vhs_hs_fsm.sv
// Module: handshake sequencer. It walks IDLE -> REQ -> RELEASE -> IDLE,
// owns the master valid strobe and the completion pulse, and decides
// when a core request is accepted and when read data is captured.
// Assumes the memory raises its response only while the strobe is high
// and drops it only after it has seen the strobe low.
module vhs_hs_fsm
    import vhs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic core_req,
    input  logic mem_vld,
    output logic cpu_vld,
    output logic accept,
    output logic capture,
    output logic done,
    output logic busy
);
    hs_state_t state;

    // Decode the accept and capture events from the current state.
    always_comb begin
        accept  = (state == HS_IDLE) && core_req;
        capture = (state == HS_REQ) && mem_vld;
        busy    = (state != HS_IDLE);
    end

    // Advance the handshake and drive the strobe and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= HS_IDLE;
            cpu_vld <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                HS_IDLE: begin
                    if (core_req) begin
                        state   <= HS_REQ;
                        cpu_vld <= 1'b1;
                    end
                end
                HS_REQ: begin
                    if (mem_vld) begin
                        state   <= HS_RELEASE;
                        cpu_vld <= 1'b0;
                        done    <= 1'b1;
                    end
                end
                HS_RELEASE: begin
                    if (!mem_vld) begin
                        state <= HS_IDLE;
                    end
                end
                default: begin
                    state   <= HS_IDLE;
                    cpu_vld <= 1'b0;
                end
            endcase
        end
    end

    // R4: the strobe falls only after the response was sampled high.
    p_drop_after_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_vld) |-> $past(mem_vld));

    // R4: while waiting without a response the strobe stays up.
    p_hold_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_vld && !mem_vld) |=> cpu_vld);

    // R6: the completion pulse never lasts two cycles.
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: once released, the strobe stays low while memory still answers.
    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cpu_vld && mem_vld) |=> !cpu_vld);

    // R8: a new strobe never follows an edge where memory was still high.
    p_clean_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_vld) |-> !$past(mem_vld));
endmodule

// File: rtl/vhs_req_hold.sv
// Module: request holding registers. On accept it loads the address,
// direction, kind and write data and keeps them unchanged until the
// next accept, so they stay stable while the strobe is high.
// Assumes accept only occurs when no transaction is in flight.
module vhs_req_hold #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  logic          cpu_vld,
    input  logic [AW-1:0] core_addr,
    input  logic          core_read,
    input  logic          core_fetch,
    input  logic [DW-1:0] core_wdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rw,
    output logic          bus_dkind,
    output logic [DW-1:0] bus_dout,
    output logic          bus_dout_en
);
    logic next_kind;

    // Writes are always data accesses; reads follow the fetch flag.
    always_comb begin
        next_kind = core_read ? ~core_fetch : 1'b1;
    end

    // Load the request fields on accept and keep them until the next accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_addr  <= '0;
            bus_rw    <= 1'b1;
            bus_dkind <= 1'b1;
            bus_dout  <= '0;
        end else if (accept) begin
            bus_addr  <= core_addr;
            bus_rw    <= core_read;
            bus_dkind <= next_kind;
            bus_dout  <= core_read ? '0 : core_wdata;
        end
    end

    // Enable write data from accept of a write until the response edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_dout_en <= 1'b0;
        end else if (accept) begin
            bus_dout_en <= ~core_read;
        end else if (capture) begin
            bus_dout_en <= 1'b0;
        end
    end

    // R3: request fields hold while the strobe stays high.
    p_fields_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_vld && $past(cpu_vld)) |-> ($stable(bus_addr) && $stable(bus_rw)
                                         && $stable(bus_dkind) && $stable(bus_dout)));

    // R7: every write on the bus is tagged as a data access.
    p_write_is_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_vld && !bus_rw) |-> bus_dkind);

    // R7: write data is driven for the whole strobe of a write.
    p_write_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_vld && !bus_rw) |-> bus_dout_en);

    // R10: write data is never driven outside a write strobe.
    p_no_drive_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dout_en |-> (cpu_vld && !bus_rw));
endmodule

// File: rtl/vhs_rd_capture.sv
// Module: read data capture. It samples the bus read data on the
// response edge of a read and holds it for the core until the next
// read completes. Assumes capture is high for exactly one edge per
// transaction.
module vhs_rd_capture #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          is_read,
    input  logic [DW-1:0] bus_din,
    output logic [DW-1:0] core_rdata
);
    // Take the read data on the first response edge of a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_rdata <= '0;
        end else if (capture && is_read) begin
            core_rdata <= bus_din;
        end
    end

    // R5: the captured value is the data present on the response edge.
    p_capture_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && is_read) |=> (core_rdata == $past(bus_din)));

    // R5: writes leave the held read data alone.
    p_hold_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !is_read) |=> $stable(core_rdata));
endmodule

// File: rtl/vhs_bus_master.sv
// Module: valid-handshake memory bus master (top). Joins the sequencer,
// the request holding registers and the read capture. Assumes one
// outstanding transaction and a memory that obeys the four-phase
// interlock.
module vhs_bus_master #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_req,
    input  logic [AW-1:0] core_addr,
    input  logic          core_read,
    input  logic          core_fetch,
    input  logic [DW-1:0] core_wdata,
    output logic          core_busy,
    output logic          core_done,
    output logic [DW-1:0] core_rdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rw,
    output logic          bus_dkind,
    output logic [DW-1:0] bus_dout,
    output logic          bus_dout_en,
    input  logic [DW-1:0] bus_din,
    output logic          bus_cpu_vld,
    input  logic          bus_mem_vld
);
    logic accept;
    logic capture;

    vhs_hs_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .core_req (core_req),
        .mem_vld  (bus_mem_vld),
        .cpu_vld  (bus_cpu_vld),
        .accept   (accept),
        .capture  (capture),
        .done     (core_done),
        .busy     (core_busy)
    );

    vhs_req_hold #(.AW(AW), .DW(DW)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .capture     (capture),
        .cpu_vld     (bus_cpu_vld),
        .core_addr   (core_addr),
        .core_read   (core_read),
        .core_fetch  (core_fetch),
        .core_wdata  (core_wdata),
        .bus_addr    (bus_addr),
        .bus_rw      (bus_rw),
        .bus_dkind   (bus_dkind),
        .bus_dout    (bus_dout),
        .bus_dout_en (bus_dout_en)
    );

    vhs_rd_capture #(.DW(DW)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .is_read    (bus_rw),
        .bus_din    (bus_din),
        .core_rdata (core_rdata)
    );

    // R9: a request during a transaction does not disturb the bus address.
    p_busy_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (core_busy && core_req) |=> $stable(bus_addr));

    // R1: idle bus after reset release.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!bus_cpu_vld && !core_done && !bus_dout_en));
endmodule

// File: tb/vhs_bus_master_bench.sv
module vhs_bus_master_bench;
    localparam int AW = 32;
    localparam int DW = 32;

    typedef struct {
        logic        rd;
        logic [31:0] addr;
        logic        kind;
        logic [31:0] wd;
        int          lat;
        int          hold;
    } bus_exp_t;

    typedef struct {
        logic        rd;
        logic [31:0] data;
    } res_exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          core_req = 1'b0;
    logic [AW-1:0] core_addr = '0;
    logic          core_read = 1'b0;
    logic          core_fetch = 1'b0;
    logic [DW-1:0] core_wdata = '0;
    logic          core_busy;
    logic          core_done;
    logic [DW-1:0] core_rdata;
    logic [AW-1:0] bus_addr;
    logic          bus_rw;
    logic          bus_dkind;
    logic [DW-1:0] bus_dout;
    logic          bus_dout_en;
    logic [DW-1:0] bus_din = '0;
    logic          bus_cpu_vld;
    logic          bus_mem_vld = 1'b0;

    int checks = 0;
    int errors = 0;
    int issued = 0;
    int done_cnt = 0;
    bit finished = 0;
    bus_exp_t bus_q[$];
    res_exp_t res_q[$];
    logic [31:0] shadow [16];
    logic [31:0] mem [16];

    always #10 clk = ~clk;

    vhs_bus_master #(.AW(AW), .DW(DW)) u_vhs_bus_master (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_addr(core_addr),
        .core_read(core_read), .core_fetch(core_fetch), .core_wdata(core_wdata),
        .core_busy(core_busy), .core_done(core_done), .core_rdata(core_rdata),
        .bus_addr(bus_addr), .bus_rw(bus_rw), .bus_dkind(bus_dkind),
        .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din),
        .bus_cpu_vld(bus_cpu_vld), .bus_mem_vld(bus_mem_vld)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] init_word(input int i);
        return 32'hA500_0000 ^ (32'(i) * 32'h0101_0101);
    endfunction

    // Driver: issue one transaction and push the expectations.
    task automatic issue(input logic rd, input logic fetch, input logic [31:0] addr,
                         input logic [31:0] wd, input int lat, input int hold);
        bus_exp_t be;
        res_exp_t re;
        @(negedge clk);
        while (core_busy) @(negedge clk);
        be.rd = rd; be.addr = addr; be.kind = rd ? ~fetch : 1'b1;
        be.wd = wd; be.lat = lat; be.hold = hold;
        re.rd = rd;
        re.data = rd ? shadow[addr[5:2]] : 32'h0;
        if (!rd) shadow[addr[5:2]] = wd;
        bus_q.push_back(be);
        res_q.push_back(re);
        issued++;
        core_req = 1'b1; core_addr = addr; core_read = rd;
        core_fetch = fetch; core_wdata = wd;
        @(negedge clk);
        core_req = 1'b0; core_addr = 32'h5555_5555; core_wdata = 32'h7777_7777;
    endtask

    // Responder: memory side of the handshake with per-transaction timing.
    initial begin
        bus_exp_t e;
        for (int i = 0; i < 16; i++) mem[i] = init_word(i);
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (!bus_cpu_vld) continue;
            if (bus_q.size() == 0) begin
                chk(1'b0, "R9 unexpected transaction", bus_addr, 32'h0);
                continue;
            end
            e = bus_q.pop_front();
            chk(bus_addr == e.addr, "R2 address", bus_addr, e.addr);
            chk(bus_rw == e.rd, "R2 direction", {31'b0, bus_rw}, {31'b0, e.rd});
            chk(bus_dkind == e.kind, "R2/R7 kind", {31'b0, bus_dkind}, {31'b0, e.kind});
            if (e.rd)
                chk(!bus_dout_en, "R10 no drive on read", {31'b0, bus_dout_en}, 32'h0);
            else
                chk(bus_dout_en && bus_dout == e.wd, "R7 write data", bus_dout, e.wd);
            for (int d = 0; d < e.lat; d++) begin
                @(negedge clk);
                chk(bus_cpu_vld, "R4 strobe held", {31'b0, bus_cpu_vld}, 32'h1);
                chk(bus_addr == e.addr && bus_rw == e.rd && bus_dkind == e.kind,
                    "R3 stable fields", bus_addr, e.addr);
            end
            if (e.rd) bus_din = mem[e.addr[5:2]];
            else mem[e.addr[5:2]] = bus_dout;
            bus_mem_vld = 1'b1;
            @(negedge clk);
            bus_din = 32'hDEAD_BEEF;
            chk(!bus_cpu_vld, "R4 strobe dropped", {31'b0, bus_cpu_vld}, 32'h0);
            chk(core_done, "R6 done timing", {31'b0, core_done}, 32'h1);
            for (int h = 0; h < e.hold; h++) begin
                @(negedge clk);
                chk(!bus_cpu_vld && core_busy && !core_done, "R8 release wait",
                    {29'b0, bus_cpu_vld, core_busy, core_done}, 32'h2);
            end
            bus_mem_vld = 1'b0;
        end
    end

    // Monitor: scoreboard of completions against the driver's expectations.
    initial begin
        res_exp_t r;
        logic [31:0] last_rd = 32'h0;
        bit prev_done = 0;
        forever begin
            @(negedge clk);
            if (rst_n && core_done) begin
                done_cnt++;
                chk(!prev_done, "R6 single pulse", 32'h1, 32'h0);
                if (res_q.size() == 0) begin
                    chk(1'b0, "R9 extra completion", 32'h1, 32'h0);
                end else begin
                    r = res_q.pop_front();
                    if (r.rd) begin
                        chk(core_rdata == r.data, "R5 read data", core_rdata, r.data);
                        last_rd = r.data;
                    end else begin
                        chk(core_rdata == last_rd, "R5 held over write", core_rdata, last_rd);
                    end
                end
            end
            prev_done = core_done;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) shadow[i] = init_word(i);
        repeat (3) @(negedge clk);
        chk(!bus_cpu_vld && !bus_dout_en && !core_busy && !core_done, "R1 in reset",
            {28'b0, bus_cpu_vld, bus_dout_en, core_busy, core_done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_cpu_vld && !bus_dout_en && !core_busy && !core_done, "R1 after reset",
            {28'b0, bus_cpu_vld, bus_dout_en, core_busy, core_done}, 32'h0);

        issue(1'b1, 1'b0, 32'h0000_0008, 32'h0, 2, 1);
        issue(1'b0, 1'b0, 32'h1000_0010, 32'h1234_5678, 1, 2);
        issue(1'b1, 1'b0, 32'h1000_0010, 32'h0, 0, 1);
        issue(1'b1, 1'b1, 32'hFFFF_FFC4, 32'h0, 3, 1);
        issue(1'b0, 1'b1, 32'h0000_003C, 32'hCAFE_F00D, 0, 1);
        issue(1'b0, 1'b0, 32'h0000_0020, 32'h0BAD_0001, 2, 3);
        issue(1'b1, 1'b1, 32'h0000_003C, 32'h0, 4, 2);

        // R9: long wait, press a conflicting request while busy.
        issue(1'b1, 1'b0, 32'h8000_0020, 32'h0, 8, 5);
        core_req = 1'b1; core_addr = 32'h0000_0004; core_read = 1'b0;
        core_fetch = 1'b0; core_wdata = 32'hFFFF_0000;
        repeat (3) @(negedge clk);
        core_req = 1'b0;

        issue(1'b0, 1'b0, 32'h0000_0004, 32'h0000_0001, 0, 1);
        issue(1'b1, 1'b0, 32'h0000_0004, 32'h0, 0, 1);
        issue(1'b1, 1'b0, 32'h0000_0030, 32'h0, 1, 4);

        @(negedge clk);
        while (core_busy || res_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(done_cnt == issued, "R9 completion count", 32'(done_cnt), 32'(issued));
        chk(!bus_cpu_vld && !core_busy, "R8 idle at end",
            {30'b0, bus_cpu_vld, core_busy}, 32'h0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule